// File: doc/BRIEF.md
# Debug-Port Cache Command Decoder

This block sits behind a serial debug data register and turns a stream of 33-bit packets into operations on two instruction caches: a main cache and a mini cache. Shifting and TAP control happen elsewhere. Each time a complete packet has been captured, the block sees one valid strobe together with the 33 parallel bits. The cache arrays also live outside the block. It drives them through one-cycle operation strobes that carry a line-aligned address and, for writes, a full 256-bit line.

A packet with its top bit set is a header. The low three bits of a header select the command. Two commands need only the header: dropping the main-cache line that holds an address, and clearing the whole mini cache. The two line-write commands, one for each cache, expect exactly eight data packets after the header. These are gathered in ascending word order, and the write is committed as one operation in the cycle after the last word arrives. The block discards headers with a reserved code and latches a sticky error. It also abandons a partial line when a reset arrives or when a fresh header interrupts it.

Top module: `icache_dbg_loader`

## Requirements
- R1: While and after the active-low reset `rst_n` is low, every strobe and `err_o` read 0, and a line write that was under way is dropped: data packets that follow the reset produce no write strobe.
- R2: A header (packet bit 32 = 1) with code bits[2:0] = 3'b000 raises `inv_main_o` for exactly one cycle, in the cycle after the packet. In that cycle `line_addr_o` equals packet bits[31:5] with bits[4:0] forced to zero, and header bits[4:3] have no effect.
- R3: A header with code 3'b001 raises only `inv_mini_o` for one cycle, in the cycle after the packet. `inv_main_o` and both write strobes stay low.
- R4: A header with code 3'b010 (main) or 3'b011 (mini), followed by eight data packets (bit 32 = 0), raises `load_main_o` or `load_mini_o` for one cycle, in the cycle after the eighth data packet. No strobe appears before that cycle. `line_addr_o` then holds the header address, aligned as in R2. Idle cycles between packets are allowed.
- R5: While a write strobe is high, `line_data_o[32k+31:32k]` holds bits[31:0] of the k-th data packet, where k = 0 for the first data packet after the header.
- R6: A header whose code has bit 2 set (3'b100 to 3'b111) raises no strobe and sets `err_o` from the next cycle on. `err_o` stays set until reset, whatever packets follow.
- R7: A header that arrives during a line write abandons the partial line without any write strobe, and is itself decoded as a new command.
- R8: At most one of the four strobes is high in any cycle.
- R9: A data packet (bit 32 = 0) that arrives when no line write is under way is ignored: no strobe and no change to `err_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pkt_valid_i | input | 1 | One-cycle strobe: a full packet is present |
| pkt_i | input | 33 | Packet bits; bit 32 marks a header |
| inv_main_o | output | 1 | Invalidate the main-cache line at `line_addr_o` |
| inv_mini_o | output | 1 | Invalidate the whole mini cache |
| load_main_o | output | 1 | Write `line_data_o` into the main cache at `line_addr_o` |
| load_mini_o | output | 1 | Write `line_data_o` into the mini cache at `line_addr_o` |
| line_addr_o | output | 32 | Line-aligned address for invalidate-line and write strobes |
| line_data_o | output | 256 | Eight assembled words, word 0 lowest |
| err_o | output | 1 | Sticky flag: a reserved code was received |

## Verification
A behavioural model in the bench holds a queue of pending words and a pending target, and the design is compared against it on every clock. The stimulus covers back-to-back packets, which catch a word-counter or commit off by one cycle, and data packets with idle gaps, which show that only valid packets advance the count. Each cache target and each single-packet code is used with bits[4:3] set, which shows address alignment and target selection. Interrupting headers, resets in the middle of a line, reserved codes and stray data packets while idle separate abort handling from normal completion, and show that the error flag stays set.

// File: rtl/icld_pkg.sv
package icld_pkg;

   localparam int CODE_W = 3;

   localparam logic [CODE_W-1:0] FN_INV_LINE = 3'b000;
   localparam logic [CODE_W-1:0] FN_INV_MINI = 3'b001;
   localparam logic [CODE_W-1:0] FN_LD_MAIN  = 3'b010;
   localparam logic [CODE_W-1:0] FN_LD_MINI  = 3'b011;

   typedef enum logic [2:0] {
      OP_NONE,
      OP_INV_MAIN,
      OP_INV_MINI,
      OP_LD_MAIN,
      OP_LD_MINI,
      OP_RSVD
   } op_e;

endpackage

// File: rtl/icld_hdr_decode.sv
module icld_hdr_decode
   import icld_pkg::*;
#(
   parameter int PKT_W = 33,
   parameter int OFF_W = 5
) (
   input  logic             pkt_valid_i,
   input  logic [PKT_W-1:0] pkt_i,
   output logic             hdr_o,
   output op_e              op_o,
   output logic [PKT_W-2:0] addr_o
);

   localparam int AW = PKT_W - 1;
   localparam logic [AW-1:0] OFF_MASK = AW'((64'd1 << OFF_W) - 64'd1);

   assign hdr_o  = pkt_valid_i & pkt_i[PKT_W-1];
   assign addr_o = pkt_i[AW-1:0] & ~OFF_MASK;

   always_comb begin
      op_o = OP_NONE;
      if (hdr_o) begin
         case (pkt_i[CODE_W-1:0])
            FN_INV_LINE: op_o = OP_INV_MAIN;
            FN_INV_MINI: op_o = OP_INV_MINI;
            FN_LD_MAIN:  op_o = OP_LD_MAIN;
            FN_LD_MINI:  op_o = OP_LD_MINI;
            default:     op_o = OP_RSVD;
         endcase
      end
   end

endmodule

// File: rtl/icld_line_asm.sv
module icld_line_asm #(
   parameter int WORD_W = 32,
   parameter int WORDS  = 8
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    clr_i,
   input  logic                    wr_i,
   input  logic [WORD_W-1:0]       wdata_i,
   output logic                    last_o,
   output logic [WORDS*WORD_W-1:0] line_o
);

   localparam int CNT_W = (WORDS > 1) ? $clog2(WORDS) : 1;

   logic [CNT_W-1:0]  cnt_q;
   logic [WORD_W-1:0] words_q [WORDS];

   assign last_o = (cnt_q == CNT_W'(WORDS - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (clr_i) begin
         cnt_q <= '0;
      end else if (wr_i) begin
         cnt_q <= last_o ? '0 : cnt_q + 1'b1;
      end
   end

   for (genvar gi = 0; gi < WORDS; gi++) begin : g_word
      always_ff @(posedge clk) begin
         if (wr_i && !clr_i && cnt_q == CNT_W'(gi)) begin
            words_q[gi] <= wdata_i;
         end
      end
      assign line_o[gi*WORD_W +: WORD_W] = words_q[gi];
   end

   // R4: after the final word the slot pointer returns to the first word
   assert_cnt_wrap_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_i && last_o && !clr_i) |=> (cnt_q == '0));

   // R7: an abort always restarts filling at word 0
   assert_clr_restart_R7: assert property (@(posedge clk) disable iff (!rst_n)
      clr_i |=> (cnt_q == '0));

endmodule

// File: rtl/icache_dbg_loader.sv
module icache_dbg_loader
   import icld_pkg::*;
#(
   parameter int PKT_W = 33,
   parameter int WORDS = 8
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic                            pkt_valid_i,
   input  logic [PKT_W-1:0]                pkt_i,
   output logic                            inv_main_o,
   output logic                            inv_mini_o,
   output logic                            load_main_o,
   output logic                            load_mini_o,
   output logic [PKT_W-2:0]                line_addr_o,
   output logic [WORDS*(PKT_W-1)-1:0]      line_data_o,
   output logic                            err_o
);

   localparam int WORD_W = PKT_W - 1;
   localparam int LINE_B = WORDS * WORD_W / 8;
   localparam int OFF_W  = $clog2(LINE_B);

   logic             hdr;
   op_e              op;
   logic [WORD_W-1:0] hdr_addr;
   logic             asm_wr;
   logic             asm_last;
   logic             busy_q;
   logic             tgt_mini_q;

   icld_hdr_decode #(
      .PKT_W (PKT_W),
      .OFF_W (OFF_W)
   ) u_dec (
      .pkt_valid_i (pkt_valid_i),
      .pkt_i       (pkt_i),
      .hdr_o       (hdr),
      .op_o        (op),
      .addr_o      (hdr_addr)
   );

   assign asm_wr = pkt_valid_i & ~pkt_i[PKT_W-1] & busy_q;

   icld_line_asm #(
      .WORD_W (WORD_W),
      .WORDS  (WORDS)
   ) u_asm (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr_i   (hdr),
      .wr_i    (asm_wr),
      .wdata_i (pkt_i[WORD_W-1:0]),
      .last_o  (asm_last),
      .line_o  (line_data_o)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         inv_main_o  <= 1'b0;
         inv_mini_o  <= 1'b0;
         load_main_o <= 1'b0;
         load_mini_o <= 1'b0;
         line_addr_o <= '0;
         busy_q      <= 1'b0;
         tgt_mini_q  <= 1'b0;
         err_o       <= 1'b0;
      end else begin
         inv_main_o  <= 1'b0;
         inv_mini_o  <= 1'b0;
         load_main_o <= 1'b0;
         load_mini_o <= 1'b0;
         if (hdr) begin
            busy_q <= 1'b0;
            case (op)
               OP_INV_MAIN: begin
                  inv_main_o  <= 1'b1;
                  line_addr_o <= hdr_addr;
               end
               OP_INV_MINI: inv_mini_o <= 1'b1;
               OP_LD_MAIN, OP_LD_MINI: begin
                  busy_q      <= 1'b1;
                  tgt_mini_q  <= (op == OP_LD_MINI);
                  line_addr_o <= hdr_addr;
               end
               OP_RSVD: err_o <= 1'b1;
               default: ;
            endcase
         end else if (asm_wr && asm_last) begin
            busy_q <= 1'b0;
            if (tgt_mini_q) load_mini_o <= 1'b1;
            else            load_main_o <= 1'b1;
         end
      end
   end

   // R8: strobes are mutually exclusive
   assert_one_strobe_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({inv_main_o, inv_mini_o, load_main_o, load_mini_o}));

   // R2: line invalidate follows its header with the aligned address
   assert_inv_addr_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (pkt_valid_i && pkt_i[PKT_W-1] && pkt_i[2:0] == FN_INV_LINE)
      |=> (inv_main_o && line_addr_o[OFF_W-1:0] == '0
           && line_addr_o[WORD_W-1:OFF_W] == $past(pkt_i[WORD_W-1:OFF_W])));

   // R3: mini clear never touches the main cache
   assert_mini_only_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (pkt_valid_i && pkt_i[PKT_W-1] && pkt_i[2:0] == FN_INV_MINI)
      |=> (inv_mini_o && !inv_main_o));

   // R6: reserved codes raise the flag and no strobe
   assert_rsvd_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (pkt_valid_i && pkt_i[PKT_W-1] && pkt_i[2])
      |=> (err_o && !inv_main_o && !inv_mini_o && !load_main_o && !load_mini_o));

   // R6: the flag is sticky
   assert_err_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
      err_o |=> err_o);

   // R4: a write commits only right after a data packet
   assert_load_after_data_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (load_main_o || load_mini_o) |-> $past(pkt_valid_i && !pkt_i[PKT_W-1]));

   // R7: a header during a line write never yields a write strobe next
   assert_abort_no_load_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (pkt_valid_i && pkt_i[PKT_W-1]) |=> (!load_main_o && !load_mini_o));

endmodule

// File: tb/icache_dbg_loader_bench.sv
module icache_dbg_loader_bench;

   localparam int PKT_W = 33;
   localparam int WORDS = 8;
   localparam int LW    = WORDS * 32;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic           pkt_valid_i = 1'b0;
   logic [32:0]    pkt_i = '0;
   logic           inv_main_o, inv_mini_o, load_main_o, load_mini_o, err_o;
   logic [31:0]    line_addr_o;
   logic [LW-1:0]  line_data_o;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   icache_dbg_loader #(.PKT_W(PKT_W), .WORDS(WORDS)) u_icache_dbg_loader (
      .clk (clk), .rst_n (rst_n), .pkt_valid_i (pkt_valid_i), .pkt_i (pkt_i),
      .inv_main_o (inv_main_o), .inv_mini_o (inv_mini_o),
      .load_main_o (load_main_o), .load_mini_o (load_mini_o),
      .line_addr_o (line_addr_o), .line_data_o (line_data_o), .err_o (err_o)
   );

   // behavioural reference
   bit          m_busy, m_tgt_mini, m_err;
   bit          e_im, e_imini, e_lmain, e_lmini;
   logic [31:0] m_addr;
   logic [31:0] m_q[$];
   logic [LW-1:0] m_line;
   bit          chk_en = 1'b0;

   always @(posedge clk) begin
      chk_en <= rst_n;
      e_im = 0; e_imini = 0; e_lmain = 0; e_lmini = 0;
      if (!rst_n) begin
         m_busy = 0; m_err = 0; m_q.delete();
      end else if (pkt_valid_i) begin
         if (pkt_i[32]) begin
            m_busy = 0;
            m_q.delete();
            if (pkt_i[2]) m_err = 1;
            else begin
               if (pkt_i[1:0] != 2'd1) m_addr = {pkt_i[31:5], 5'b0};
               if (pkt_i[1:0] == 2'd0) e_im = 1;
               else if (pkt_i[1:0] == 2'd1) e_imini = 1;
               else begin m_busy = 1; m_tgt_mini = pkt_i[0]; end
            end
         end else if (m_busy) begin
            m_q.push_back(pkt_i[31:0]);
            if (m_q.size() == WORDS) begin
               for (int k = 0; k < WORDS; k++) m_line[k*32 +: 32] = m_q[k];
               m_q.delete();
               m_busy = 0;
               if (m_tgt_mini) e_lmini = 1; else e_lmain = 1;
            end
         end
      end
   end

   task automatic chk(input string tag, input logic [LW-1:0] act, input logic [LW-1:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual %0h expected %0h at %0t", tag, act, exp, $time);
      end
   endtask

   int n_load = 0;
   int n_strobe = 0;

   always @(negedge clk) begin
      if (chk_en && !done) begin
         chk("R2 inv_main", LW'(inv_main_o), LW'(e_im));
         chk("R3 inv_mini", LW'(inv_mini_o), LW'(e_imini));
         chk("R4 load_main", LW'(load_main_o), LW'(e_lmain));
         chk("R4 load_mini", LW'(load_mini_o), LW'(e_lmini));
         chk("R6 err", LW'(err_o), LW'(m_err));
         chk("R8 onehot", LW'($countones({inv_main_o, inv_mini_o, load_main_o, load_mini_o}) <= 1), LW'(1));
         if (e_im || e_lmain || e_lmini) chk("R2 R4 addr", LW'(line_addr_o), LW'(m_addr));
         if (e_lmain || e_lmini) chk("R5 line", line_data_o, m_line);
         if (load_main_o || load_mini_o) n_load++;
         if (inv_main_o || inv_mini_o || load_main_o || load_mini_o) n_strobe++;
      end
   end

   function automatic logic [32:0] hdr(input logic [2:0] code, input logic [31:0] a);
      return {1'b1, a[31:5], 2'b11, code};
   endfunction

   task automatic send(input logic [32:0] p);
      pkt_valid_i = 1'b1;
      pkt_i = p;
      @(negedge clk);
      pkt_valid_i = 1'b0;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic send_words(input int n, input logic [31:0] seed, input int gap);
      for (int k = 0; k < n; k++) begin
         send({1'b0, seed ^ (32'h0101_0101 * k) ^ {k[15:0], 16'h5a5a}});
         if (gap > 0) idle(gap);
      end
   endtask

   initial begin
      int base;
      idle(3);
      chk("R1 reset strobes", LW'({inv_main_o, inv_mini_o, load_main_o, load_mini_o}), LW'(0));
      chk("R1 reset err", LW'(err_o), LW'(0));
      rst_n = 1'b1;
      idle(2);

      send(hdr(3'b000, 32'h1234_567f)); idle(2);
      send(hdr(3'b001, 32'hffff_ffff)); idle(2);
      send(hdr(3'b010, 32'hdead_beef)); send_words(8, 32'hcafe_0000, 0); idle(2);
      send(hdr(3'b011, 32'h0000_0020)); send_words(8, 32'h1357_9bdf, 2); idle(2);
      send(hdr(3'b010, 32'h8000_0000)); send_words(8, 32'h0, 1);
      send(hdr(3'b011, 32'h4444_4444)); send_words(8, 32'hffff_ffff, 0); idle(2);
      chk("R4 load count", LW'(n_load), LW'(4));

      base = n_strobe;
      send_words(5, 32'h7777_0000, 0); idle(2);
      chk("R9 stray data", LW'(n_strobe - base), LW'(0));
      chk("R9 err untouched", LW'(err_o), LW'(0));

      base = n_load;
      send(hdr(3'b010, 32'h0bad_0000)); send_words(4, 32'h2222_0000, 0);
      send(hdr(3'b000, 32'h0000_1040)); send_words(4, 32'h3333_0000, 0); idle(2);
      chk("R7 abort no load", LW'(n_load - base), LW'(0));
      send(hdr(3'b011, 32'h00ab_cd00)); send_words(3, 32'h4444_0000, 0);
      send(hdr(3'b010, 32'h0f0f_0f00)); send_words(8, 32'h5555_0000, 0); idle(2);
      chk("R7 restart load", LW'(n_load - base), LW'(1));

      send(hdr(3'b101, 32'h1111_1100)); idle(2);
      chk("R6 err set", LW'(err_o), LW'(1));
      send(hdr(3'b111, 32'h0)); send(hdr(3'b100, 32'h0)); send(hdr(3'b110, 32'h0));
      send(hdr(3'b000, 32'h2000_0000)); send(hdr(3'b010, 32'h3000_0000));
      send_words(8, 32'h6666_0000, 0); idle(2);
      chk("R6 err sticky", LW'(err_o), LW'(1));

      base = n_load;
      send(hdr(3'b011, 32'h9000_0000)); send_words(3, 32'h8888_0000, 0);
      rst_n = 1'b0; idle(2);
      chk("R1 mid reset err", LW'(err_o), LW'(0));
      rst_n = 1'b1; idle(1);
      send_words(5, 32'h9999_0000, 0); idle(3);
      chk("R1 dropped load", LW'(n_load - base), LW'(0));
      send(hdr(3'b011, 32'h9000_0000)); send_words(8, 32'habcd_0000, 0); idle(2);
      chk("R1 after reset", LW'(n_load - base), LW'(1));

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         checks++;
         errors++;
         $display("FAIL watchdog actual timeout expected completion");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

endmodule